// File: doc/BRIEF.md
# Sine-Breathing LED Driver

This block makes a single status LED glow up and fade out smoothly, following a sine curve rather than switching abruptly on and off. One free-running counter does all the timing. Its lower bits form the sawtooth of a pulse-width modulator. Its upper bits step through a sine lookup table. The contents of that table are computed when the design is elaborated, so no arithmetic runs at run time. The value read from the table is registered and then used as the modulator's duty value. As a result, the brightness seen by the eye traces one sine period for every full wrap of the counter.

The driver has only a clock, a synchronous reset request and the LED pin. The reset request passes through a short synchroniser chain, which releases the internal reset cleanly. Two parameters set the scale of the whole waveform. The duty resolution sets both the number of table entries and the width of each entry. The total counter width sets the breathing period.

Top module: `breath_led_ctrl`

## Requirements
- R1: While the internal reset is active, `led_o` is low and the counter is held at zero. The internal reset goes active one clock edge after `rst_i` is sampled high.
- R2: The internal reset is the last stage of a SYNC_STAGES-deep chain. Every stage is set while `rst_i` is high, and a zero shifts in otherwise. The counter therefore starts counting SYNC_STAGES edges after `rst_i` is sampled low.
- R3: Table entry i holds round((1 + sin(2π·i / 2^PWM_BITS)) · (2^PWM_BITS − 1) / 2), with halves rounded up. An input of sine −1 gives code 0, and sine +1 gives the all-ones code.
- R4: The table is addressed by the top PWM_BITS bits of the counter, and the read is registered. During the cycle in which the counter reads c, the duty in force is the entry for the upper bits of c−1. For the first cycle after reset, it is entry 0.
- R5: `led_o` is a register. In the cycle after count c, it is high when the low PWM_BITS bits of c are strictly below the duty in force, or when that duty is the all-ones code. A duty of all ones keeps the LED continuously lit.
- R6: A duty of zero keeps `led_o` low.
- R7: The counter advances by one every cycle and wraps. The LED pattern repeats every 2^CNT_BITS cycles. In one period, the number of high cycles equals the sum, over all entries, of 2^(CNT_BITS−2·PWM_BITS) times the entry value, where an all-ones entry counts as 2^PWM_BITS.
- R8: Around the sine peak, `led_o` stays high for at least 2^(CNT_BITS−PWM_BITS) consecutive cycles. Around the trough, it stays low for at least that long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_i | input | 1 | Active-high reset request; it is synchronised before use |
| led_o | output | 1 | Registered pulse-width-modulated LED drive |

## Verification
Any fault inside the driver shows up on the single LED pin within one cycle. This holds for a counter that skips a step, a table entry off by one code, a duty register that latches the wrong address, or a compare using the wrong bound. The bench predicts the pin value for every cycle and compares it each cycle, so such faults are caught at once. Faults that only change the total lit time, such as an extra cycle per period, are caught by counting high cycles over a whole period. A table that never reaches its extremes is caught by measuring the longest steady stretches near the peak and the trough. Repeated reset pulses at random points in the wave check that the restart is exact, including the delay of the synchroniser.

// File: rtl/breath_pkg.sv
package breath_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Sine code for table slot idx: one full period across 2**abits slots,
    // scaled from [-1,1] onto [0, 2**dbits-1], rounded half up.
    function automatic int sine_code(input int idx, input int abits, input int dbits);
        real angle;
        real scaled;
        angle  = TWO_PI * real'(idx) / (2.0 ** abits);
        scaled = (1.0 + $sin(angle)) * ((2.0 ** dbits) - 1.0) / 2.0;
        return $rtoi(scaled + 0.5);
    endfunction

endpackage

// File: rtl/breath_rst_sync.sv
module breath_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic req_i,
    output logic rst_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d;
    sync_t s_q;

    always_comb begin
        s_d = s_q;
        if (req_i) begin
            s_d.chain = '1;
        end else begin
            s_d.chain = {s_q.chain[STAGES-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign rst_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/breath_counter.sv
module breath_counter #(
    parameter int WIDTH = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic [WIDTH-1:0] count_o
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_t;

    cnt_t c_d;
    cnt_t c_q;

    always_comb begin
        c_d = c_q;
        if (rst_i) begin
            c_d.count = '0;
        end else begin
            c_d.count = c_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        c_q <= c_d;
    end

    assign count_o = c_q.count;
endmodule

// File: rtl/breath_sine_rom.sv
module breath_sine_rom #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o
);
    localparam int DEPTH = 2 ** ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] table_w [DEPTH];
    rd_t r_d;
    rd_t r_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_w[g] = DATA_W'(breath_pkg::sine_code(g, ADDR_W, DATA_W));
    end

    always_comb begin
        r_d      = r_q;
        r_d.data = table_w[addr_i];
    end

    // Storage and read register carry no reset.
    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign data_o = r_q.data;
endmodule

// File: rtl/breath_pwm.sv
module breath_pwm #(
    parameter int RES = 4
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic [RES-1:0] phase_i,
    input  logic [RES-1:0] duty_i,
    output logic           pwm_o
);
    localparam logic [RES-1:0] FULL = '1;

    typedef struct packed {
        logic out;
    } pwm_t;

    pwm_t p_d;
    pwm_t p_q;

    always_comb begin
        p_d = p_q;
        if (rst_i) begin
            p_d.out = 1'b0;
        end else if (duty_i == FULL) begin
            p_d.out = 1'b1;
        end else begin
            p_d.out = (phase_i < duty_i);
        end
    end

    always_ff @(posedge clk_i) begin
        p_q <= p_d;
    end

    assign pwm_o = p_q.out;
endmodule

// File: rtl/breath_led_ctrl.sv
module breath_led_ctrl #(
    parameter int PWM_BITS    = 4,
    parameter int CNT_BITS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic led_o
);
    localparam int ADDR_LSB = CNT_BITS - PWM_BITS;
    localparam logic [PWM_BITS-1:0] DUTY_MAX = '1;

    logic                rst_int;
    logic [CNT_BITS-1:0] cnt;
    logic [PWM_BITS-1:0] rom_addr;
    logic [PWM_BITS-1:0] phase;
    logic [PWM_BITS-1:0] duty;

    assign rom_addr = cnt[CNT_BITS-1:ADDR_LSB];
    assign phase    = cnt[PWM_BITS-1:0];

    breath_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i (clk_i),
        .req_i (rst_i),
        .rst_o (rst_int)
    );

    breath_counter #(.WIDTH(CNT_BITS)) i_cnt (
        .clk_i   (clk_i),
        .rst_i   (rst_int),
        .count_o (cnt)
    );

    breath_sine_rom #(.ADDR_W(PWM_BITS), .DATA_W(PWM_BITS)) i_rom (
        .clk_i  (clk_i),
        .addr_i (rom_addr),
        .data_o (duty)
    );

    breath_pwm #(.RES(PWM_BITS)) i_pwm (
        .clk_i   (clk_i),
        .rst_i   (rst_int),
        .phase_i (phase),
        .duty_i  (duty),
        .pwm_o   (led_o)
    );

    AST_RESET_DARK: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_int |=> (!led_o && cnt == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i || rst_int)
        1'b1 |=> (cnt == $past(cnt) + 1'b1)); // R7

    AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i || rst_int)
        (rom_addr == $past(rom_addr)) |=> (duty == $past(duty))); // R4

    AST_FULL_ON: assert property (@(posedge clk_i) disable iff (rst_i || rst_int)
        (duty == DUTY_MAX) |=> led_o); // R5

    AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (rst_i || rst_int)
        (duty == '0) |=> !led_o); // R6
endmodule

// File: tb/test_breath_led_ctrl.sv
`timescale 1ns/1ps
module test_breath_led_ctrl;
    localparam int P      = 4;
    localparam int C      = 10;
    localparam int NSYNC  = 2;
    localparam int DEPTH  = 2 ** P;
    localparam int PERIOD = 2 ** C;
    localparam int HOLD   = 2 ** (C - P);
    localparam int REP    = 2 ** (C - 2 * P);
    localparam int MAXC   = DEPTH - 1;

    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic led_o;

    int checks = 0;
    int errors = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    int tbl [DEPTH];

    logic [NSYNC-1:0] m_sync = '0;
    logic [C-1:0]     m_cnt  = '0;
    int               m_duty = 0;
    logic             m_led  = 1'b0;
    int               since_rel = 0;

    breath_led_ctrl #(.PWM_BITS(P), .CNT_BITS(C), .SYNC_STAGES(NSYNC)) i_breath_led_ctrl (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .led_o (led_o)
    );

    always #2.5 clk_i = ~clk_i;

    function automatic int bench_sine(input int i);
        real a;
        real v;
        a = 2.0 * 3.141592653589793 * real'(i) / real'(DEPTH);
        v = (1.0 + $sin(a)) * real'(MAXC) / 2.0;
        return $rtoi(v + 0.5);
    endfunction

    // Reference model of the pin, built from R1..R5.
    always @(posedge clk_i) begin
        m_sync <= rst_i ? '1 : {m_sync[NSYNC-2:0], 1'b0};
        if (m_sync[NSYNC-1]) begin
            m_cnt     <= '0;
            m_led     <= 1'b0;
            since_rel <= 0;
        end else begin
            m_cnt     <= m_cnt + 1'b1;
            m_led     <= (m_duty == MAXC) || (int'(m_cnt[P-1:0]) < m_duty);
            since_rel <= since_rel + 1;
        end
        m_duty <= tbl[m_cnt[C-1:C-P]];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    int hi_run = 0, lo_run = 0, best_hi = 0, best_lo = 0;

    always @(negedge clk_i) begin
        if (chk_en) begin
            string tag;
            if (m_sync[NSYNC-1] || since_rel == 0) tag = "R1";
            else if (since_rel < 3) tag = "R2";
            else if (m_led && m_duty == MAXC) tag = "R5";
            else if (m_duty == 0) tag = "R6";
            else tag = "R4 R3";
            check(led_o === m_led, tag, int'(led_o), int'(m_led));
            if (led_o) begin hi_run++; lo_run = 0; end
            else begin lo_run++; hi_run = 0; end
            if (hi_run > best_hi) best_hi = hi_run;
            if (lo_run > best_lo) best_lo = lo_run;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_hi;
        int got_hi;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) tbl[i] = bench_sine(i);
        exp_hi = 0;
        for (int i = 0; i < DEPTH; i++) exp_hi += REP * ((tbl[i] == MAXC) ? DEPTH : tbl[i]);

        rst_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk_en = 1'b1;
        repeat (3) @(negedge clk_i);
        check(led_o === 1'b0, "R1", int'(led_o), 0);
        rst_i = 1'b0;

        // R7: lit cycles over one steady-state period
        repeat (20) @(negedge clk_i);
        got_hi = 0;
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk_i);
            if (led_o) got_hi++;
        end
        check(got_hi == exp_hi, "R7", got_hi, exp_hi);
        repeat (PERIOD) @(negedge clk_i);
        // R8: steady stretches at peak and trough
        check(best_hi >= HOLD, "R8", best_hi, HOLD);
        check(best_lo >= HOLD, "R8", best_lo, HOLD);

        // Directed: one-cycle reset pulse at an arbitrary phase (R1, R2)
        repeat (333) @(negedge clk_i);
        rst_i = 1'b1;
        @(negedge clk_i);
        rst_i = 1'b0;
        @(negedge clk_i);
        check(led_o === 1'b0, "R1", int'(led_o), 0);
        repeat (500) @(negedge clk_i);

        // Random reset pulses at random points of the wave
        for (int n = 0; n < 30; n++) begin
            repeat ($urandom_range(3 * PERIOD, 1)) @(negedge clk_i);
            rst_i = 1'b1;
            repeat ($urandom_range(4, 1)) @(negedge clk_i);
            rst_i = 1'b0;
        end
        repeat (PERIOD) @(negedge clk_i);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule